// File: doc/BRIEF.md
# Two-Digit Decimal Modulo-60 Counter

This block counts from 00 to 59 in two binary-coded-decimal digits and then returns to 00. It serves as the seconds or the minutes section of a time-of-day chain. Each instance advances once for each clock edge on which its count enable is high. That enable comes either from a base tick or from the carry of the stage below.

A lower digit (units, 0 to 9) drives a higher digit (tens, 0 to 5). The tens digit advances only on the edge where the units digit rolls over from 9. When the tens digit reaches its last value it is reloaded with zero on the next step, so the wrap is fully synchronous and no decode of an illegal value reaches a clear input. While the stage holds 59 and is enabled, a carry output is raised to step the next stage on the same edge that this stage returns to 00. Every stage of a chain uses the same clock.

Top module: `mod60_bcd_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, both digits are 0000 after that edge.
- R2: When `rst` is high, the count enable has no effect: after the edge both digits are zero, whatever the enable and the earlier count.
- R3: When `cnt_en` is low at a rising edge (and `rst` is low), both digits keep their values.
- R4: The units digit (`units_o`, 4-bit BCD) steps by one on each enabled edge and goes from 1001 (9) to 0000.
- R5: The tens digit (`tens_o`, 4-bit BCD) steps by one on exactly the enabled edge where the units digit goes from 9 to 0, and holds on every other edge.
- R6: On the enabled edge at count 59 the tens digit goes from 0101 (5) to 0000, so the count becomes 00. The tens digit never takes the value 6.
- R7: After any reset, the units digit stays in 0..9 and the tens digit in 0..5.
- R8: `carry_o` is high in a cycle exactly when the units digit is 9, the tens digit is 5 and `cnt_en` is high. It depends on those inputs combinationally, within the same cycle.
- R9: With `cnt_en` held high, `carry_o` is high for exactly one cycle in every 60, and the count is 00 in the cycle after each carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable (base tick or carry from the lower stage) |
| units_o | output | 4 | Units digit, BCD |
| tens_o | output | 4 | Tens digit, BCD |
| carry_o | output | 1 | Enable for the next stage: count is 59 and `cnt_en` is high |

## Verification
A wrong terminal decode in either digit shows at the ports within one enabled edge. The digit then either takes an out-of-range value such as 1010 or 0110, or returns to zero early, and the bench's arithmetic model shows the mismatch on the next sampled cycle. A broken link between the units rollover and the tens step shows as a tens value that is off by one no later than ten enabled edges after reset. A carry that ignores the enable, or that lasts more than one cycle, appears at count 59. The bench holds the count there with the enable low, and it also measures the run length of the carry pulse over two full cycles of 60.

// File: rtl/mod60_pkg.sv
package mod60_pkg;
  localparam int BCD_W = 4;
  typedef logic [BCD_W-1:0] bcd_t;

  // value a digit takes on an enabled step, wrapping after its last value
  function automatic bcd_t bcd_advance(input bcd_t cur, input bcd_t last);
    bcd_t nxt;
    if (cur == last) nxt = '0;
    else             nxt = cur + bcd_t'(1);
    return nxt;
  endfunction

  // terminal flag of a digit
  function automatic logic bcd_is_last(input bcd_t cur, input bcd_t last);
    return cur == last;
  endfunction
endpackage

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
  import mod60_pkg::*;
#(
  parameter int LAST = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output bcd_t value,
  output logic at_last
);
  localparam bcd_t LAST_V = bcd_t'(LAST);

  bcd_t cur_q;

  always_ff @(posedge clk) begin
    if (rst)       cur_q <= '0;
    else if (step) cur_q <= bcd_advance(cur_q, LAST_V);
  end

  assign value   = cur_q;
  assign at_last = bcd_is_last(cur_q, LAST_V);

  // R7: digit stays within its decimal range
  assert_digit_range_R7: assert property (@(posedge clk) disable iff (rst)
    cur_q <= LAST_V);

  // R3: no step, no change
  assert_digit_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cur_q));

  // R4/R6: a step at the last value returns the digit to zero
  assert_digit_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (step && at_last) |=> cur_q == '0);
endmodule

// File: rtl/mod60_bcd_counter.sv
module mod60_bcd_counter
  import mod60_pkg::*;
#(
  parameter int UNITS_LAST = 9,
  parameter int TENS_LAST  = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cnt_en,
  output logic [3:0] units_o,
  output logic [3:0] tens_o,
  output logic       carry_o
);
  localparam int NDIG = 2;

  function automatic int last_of(input int idx);
    return (idx == 0) ? UNITS_LAST : TENS_LAST;
  endfunction

  bcd_t digit_val [NDIG];
  logic digit_tc  [NDIG];
  logic digit_step[NDIG+1];

  assign digit_step[0] = cnt_en;

  for (genvar g = 0; g < NDIG; g++) begin : g_digit
    bcd_digit_stage #(.LAST(last_of(g))) u_dig (
      .clk    (clk),
      .rst    (rst),
      .step   (digit_step[g]),
      .value  (digit_val[g]),
      .at_last(digit_tc[g])
    );
    // a higher digit is enabled only by the terminal flag of the one below
    assign digit_step[g+1] = digit_step[g] & digit_tc[g];
  end

  assign units_o = digit_val[0];
  assign tens_o  = digit_val[1];
  assign carry_o = digit_step[NDIG];

  // R4: units advance by one away from the terminal value
  assert_units_step_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && units_o != 4'd9) |=> units_o == $past(units_o) + 4'd1);

  // R5: tens advance on the units rollover edge
  assert_tens_follow_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && units_o == 4'd9 && tens_o != 4'd5) |=> tens_o == $past(tens_o) + 4'd1);

  // R5: tens hold while units are not rolling over
  assert_tens_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (units_o != 4'd9) |=> $stable(tens_o));

  // R9: the cycle after a carry shows 00
  assert_rollover_R9: assert property (@(posedge clk) disable iff (rst)
    carry_o |=> (units_o == 4'd0 && tens_o == 4'd0));

  // R8: no carry without enable
  assert_carry_gated_R8: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |-> !carry_o);
endmodule

// File: tb/sim_mod60_bcd_counter.sv
module sim_mod60_bcd_counter;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_en = 1'b0;
  logic [3:0] units_o, tens_o;
  logic carry_o;

  int n_checks = 0;
  int n_fail = 0;
  int model = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  mod60_bcd_counter u0 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en),
    .units_o(units_o), .tens_o(tens_o), .carry_o(carry_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (model count %0d)", req, act, exp, model);
    end
  endtask

  task automatic check_outputs(input string req, input logic en);
    chk({req, " units"}, int'(units_o), model % 10);
    chk({req, " tens"},  int'(tens_o),  model / 10);
    chk("R8 carry", int'(carry_o), (en && model == 59) ? 1 : 0);
  endtask

  // one cycle: drive at falling edge, check before the rising edge, then advance the model
  task automatic run_cycle(input logic en, input string req);
    @(negedge clk);
    cnt_en = en;
    #1;
    check_outputs(req, en);
    @(posedge clk);
    if (en) model = (model + 1) % 60;
  endtask

  task automatic do_reset(input logic en);
    @(negedge clk);
    rst = 1'b1;
    cnt_en = en;
    @(posedge clk);
    model = 0;
    @(negedge clk);
    rst = 1'b0;
    cnt_en = 1'b0;
    #1;
    chk("R1 units after reset", int'(units_o), 0);
    chk("R1 tens after reset", int'(tens_o), 0);
  endtask

  initial begin
    int run_len;
    int gap;
    int pulses;
    logic carry_seen;

    repeat (2) @(posedge clk);
    // R2: reset wins over an active enable
    do_reset(1'b1);

    // R4 R5 R6 R9: two full cycles with enable held high
    run_len = 0; gap = 0; pulses = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      cnt_en = 1'b1;
      #1;
      check_outputs("R4/R5/R6", 1'b1);
      carry_seen = carry_o;
      if (carry_seen) begin
        run_len++;
        pulses++;
        if (pulses > 1) chk("R9 carry period", gap, 59);
        gap = 0;
      end else begin
        if (run_len != 0) chk("R9 carry width", run_len, 1);
        run_len = 0;
        gap++;
      end
      @(posedge clk);
      model = (model + 1) % 60;
    end
    chk("R9 carry pulses in 120 steps", pulses, 2);
    #1;
    chk("R9 count after last carry units", int'(units_o), 0);
    chk("R9 count after last carry tens", int'(tens_o), 0);

    // R3: hold at 59 with enable low; carry must stay low
    for (int i = 0; i < 59; i++) run_cycle(1'b1, "R4");
    for (int i = 0; i < 5; i++) run_cycle(1'b0, "R3 hold");
    run_cycle(1'b1, "R6 wrap");
    run_cycle(1'b0, "R3 hold after wrap");

    // R3 R5: irregular enable pattern over several cycles of 60
    for (int i = 0; i < 400; i++) run_cycle(((i * 7 + i / 3) % 5) != 0, "R3/R5 gated");

    // R1 R2: reset from a mid count with enable low, then with enable high
    for (int i = 0; i < 37; i++) run_cycle(1'b1, "R4");
    do_reset(1'b0);
    for (int i = 0; i < 19; i++) run_cycle(1'b1, "R5");
    do_reset(1'b1);
    for (int i = 0; i < 65; i++) run_cycle(1'b1, "R7 after reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule